// File: doc/BRIEF.md
# Sectored Address Translation Buffer

This block is a small, fully associative translation cache. One tag covers a sector: a run of adjacent virtual pages whose page table entries were fetched together. Each page slot in the sector keeps its own valid bit next to its frame number and permission bits. Because a whole sector is loaded at once, a live entry can hold slots whose translations are not valid. Such a slot never produces a hit.

A lookup is purely combinational against the stored state. The requester presents `lk_valid` with a virtual address and gets hit, frame and permissions back in the same cycle. On a miss, an external walker fetches the sector and returns it on the fill port, along with the address that missed. The fill port is a valid/ready interface. `fill_ready` is low in any cycle that carries a flush or a single-address invalidate, and high in every other cycle. A fill is taken only on a cycle where `fill_valid` and `fill_ready` are both high, and it is written at that clock edge. A requester that sees `fill_ready` low must hold its fill and offer it again. Flush and invalidate are plain control pins. The page offset width is fixed, so only one page size exists.

Top module: `tlb_sectored`

## Requirements
- R1: After reset no lookup hits, and `lk_pfn`/`lk_perm` read zero on every miss.
- R2: The slot index is the address field `[OFF_W+SLOT_W-1:OFF_W]` (bits 13:12 by default), the tag is every bit above it, and the page offset below it is ignored. A hit needs a valid entry with an equal tag and a set valid bit on the selected slot. A hit returns that slot's frame and permissions.
- R3: An accepted fill whose missing slot (selected by `fill_vaddr`) is valid writes the whole sector, invalid siblings included. Frame `s` comes from `fill_pfn[s*PFN_W +: PFN_W]` and permissions `s` from `fill_perm[s*PERM_W +: PERM_W]`. Looking up one of the invalid siblings still misses.
- R4: An accepted fill whose missing slot is invalid, including a sector with every slot invalid, leaves the buffer unchanged.
- R5: `lk_hit` is never high while `lk_valid` is low.
- R6: A fill whose tag already sits in a valid entry overwrites that entry, so a tag never occupies two entries.
- R7: A fill for a new tag goes to the lowest-numbered entry that is not valid. If every entry is valid, a round-robin pointer picks the victim. The pointer starts at entry 0 and advances only when it is used.
- R8: `flush` clears every entry in one cycle.
- R9: `inv_valid` clears only the entry whose tag matches `inv_vaddr`.
- R10: `fill_ready` is low while `flush` or `inv_valid` is high, and a fill offered then is not taken.
- R11: A lookup in the same cycle as an accepted fill sees the contents from before the fill. The fill is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Translation hit |
| lk_pfn | output | PFN_W | Physical frame on hit, else zero |
| lk_perm | output | PERM_W | Permission bits on hit, else zero |
| fill_valid | input | 1 | Fill offered |
| fill_ready | output | 1 | Fill can be taken this cycle |
| fill_vaddr | input | VA_W | Address that missed |
| fill_pte_v | input | GROUP | Per-slot valid bits of the sector |
| fill_pfn | input | GROUP*PFN_W | Per-slot frames, slot 0 in the low bits |
| fill_perm | input | GROUP*PERM_W | Per-slot permissions, slot 0 in the low bits |
| inv_valid | input | 1 | Invalidate the entry matching inv_vaddr |
| inv_vaddr | input | VA_W | Address to invalidate |
| flush | input | 1 | Clear all entries |

## Verification
Every slot of every stored tag is swept with frames and permissions computed from tag and slot. This exposes any wrong slot select or data crossing between entries. Sectors are filled with mixed valid masks, with a valid or an invalid missing slot, and with all slots invalid. These cases separate the write and no-write fill paths and the per-slot hit gating. Refills of a resident tag, fills into a full buffer, and fills after an invalidate distinguish the same-entry, round-robin and first-free choices. Lookups issued in the fill cycle, and fills offered while an invalidate is active, pin down the ordering and back-pressure rules.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Reason an entry was chosen as the fill target.
  typedef enum logic [1:0] {
    TGT_HIT  = 2'd0,
    TGT_FREE = 2'd1,
    TGT_RR   = 2'd2
  } tgt_src_e;
endpackage

// File: rtl/tlb_tag_cam.sv
module tlb_tag_cam #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 18,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TAG_W-1:0]   lk_tag,
  input  logic [TAG_W-1:0]   fl_tag,
  input  logic [TAG_W-1:0]   inv_tag,
  input  logic               clr_all,
  input  logic               clr_one,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  output logic [ENTRIES-1:0] lk_match,
  output logic [ENTRIES-1:0] fl_match,
  output logic [ENTRIES-1:0] inv_match,
  output logic [ENTRIES-1:0] ent_v
);
  logic [TAG_W-1:0] tag_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign lk_match[e]  = ent_v[e] && (tag_q[e] == lk_tag);
    assign fl_match[e]  = ent_v[e] && (tag_q[e] == fl_tag);
    assign inv_match[e] = ent_v[e] && (tag_q[e] == inv_tag);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_v[e] <= 1'b0;
        tag_q[e] <= '0;
      end else if (clr_all) begin
        ent_v[e] <= 1'b0;
      end else if (clr_one && inv_match[e]) begin
        ent_v[e] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        ent_v[e] <= 1'b1;
        tag_q[e] <= fl_tag;
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] hit_vec,
  input  logic [ENTRIES-1:0] ent_v,
  input  logic               commit,
  output logic [IDX_W-1:0]   idx,
  output tgt_src_e           src
);
  logic [IDX_W-1:0] rr_q;

  always_comb begin
    idx = rr_q;
    src = TGT_RR;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!ent_v[e]) begin
        idx = IDX_W'(e);
        src = TGT_FREE;
      end
    end
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (hit_vec[e]) begin
        idx = IDX_W'(e);
        src = TGT_HIT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (commit && (src == TGT_RR)) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_sectored.sv
module tlb_sectored
  import tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int GROUP   = 4,
  parameter int ENTRIES = 4,
  parameter int PFN_W   = 20,
  parameter int PERM_W  = 3,
  localparam int SLOT_W = $clog2(GROUP),
  localparam int TAG_W  = VA_W - OFF_W - SLOT_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_valid,
  input  logic [VA_W-1:0]         lk_vaddr,
  output logic                    lk_hit,
  output logic [PFN_W-1:0]        lk_pfn,
  output logic [PERM_W-1:0]       lk_perm,
  input  logic                    fill_valid,
  output logic                    fill_ready,
  input  logic [VA_W-1:0]         fill_vaddr,
  input  logic [GROUP-1:0]        fill_pte_v,
  input  logic [GROUP*PFN_W-1:0]  fill_pfn,
  input  logic [GROUP*PERM_W-1:0] fill_perm,
  input  logic                    inv_valid,
  input  logic [VA_W-1:0]         inv_vaddr,
  input  logic                    flush
);
  logic [SLOT_W-1:0]  lk_slot, fill_slot;
  logic [ENTRIES-1:0] lk_match, fl_match, inv_match, ent_v;
  logic               fill_acc, fill_wr;
  logic [IDX_W-1:0]   tgt_idx;
  tgt_src_e           tgt_src;

  logic [GROUP-1:0]  pv_q   [ENTRIES];
  logic [PFN_W-1:0]  pfn_q  [ENTRIES][GROUP];
  logic [PERM_W-1:0] perm_q [ENTRIES][GROUP];

  assign lk_slot    = lk_vaddr[OFF_W +: SLOT_W];
  assign fill_slot  = fill_vaddr[OFF_W +: SLOT_W];
  assign fill_ready = !flush && !inv_valid;
  assign fill_acc   = fill_valid && fill_ready;
  assign fill_wr    = fill_acc && fill_pte_v[fill_slot];

  tlb_tag_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_tag    (lk_vaddr[VA_W-1 -: TAG_W]),
    .fl_tag    (fill_vaddr[VA_W-1 -: TAG_W]),
    .inv_tag   (inv_vaddr[VA_W-1 -: TAG_W]),
    .clr_all   (flush),
    .clr_one   (inv_valid),
    .wr_en     (fill_wr),
    .wr_idx    (tgt_idx),
    .lk_match  (lk_match),
    .fl_match  (fl_match),
    .inv_match (inv_match),
    .ent_v     (ent_v)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_vec (fl_match),
    .ent_v   (ent_v),
    .commit  (fill_wr),
    .idx     (tgt_idx),
    .src     (tgt_src)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_data
    for (genvar s = 0; s < GROUP; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (fill_wr && (tgt_idx == IDX_W'(e))) begin
          pv_q[e][s]   <= fill_pte_v[s];
          pfn_q[e][s]  <= fill_pfn[s*PFN_W +: PFN_W];
          perm_q[e][s] <= fill_perm[s*PERM_W +: PERM_W];
        end
      end
    end
  end

  logic [GROUP-1:0]  sel_pv;
  logic [PFN_W-1:0]  sel_pfn;
  logic [PERM_W-1:0] sel_perm;

  always_comb begin
    sel_pv   = '0;
    sel_pfn  = '0;
    sel_perm = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lk_match[e]) begin
        sel_pv   = sel_pv   | pv_q[e];
        sel_pfn  = sel_pfn  | pfn_q[e][lk_slot];
        sel_perm = sel_perm | perm_q[e][lk_slot];
      end
    end
  end

  assign lk_hit  = lk_valid && (|lk_match) && sel_pv[lk_slot];
  assign lk_pfn  = lk_hit ? sel_pfn  : '0;
  assign lk_perm = lk_hit ? sel_perm : '0;
endmodule

// File: rtl/tlb_sectored_chk.sv
module tlb_sectored_chk #(
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_hit,
  input logic               fill_ready,
  input logic               inv_valid,
  input logic               flush,
  input logic               fill_acc,
  input logic               fill_wr,
  input logic [ENTRIES-1:0] lk_match,
  input logic [ENTRIES-1:0] ent_v
);
  a_r5_hit_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid);

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_v == '0));

  a_r10_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (flush || inv_valid) |-> !fill_ready);

  a_r4_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_acc && !fill_wr) |=> $stable(ent_v));

  a_r3_fill_allocates: assert property (@(posedge clk) disable iff (!rst_n)
    fill_wr |=> (ent_v != '0));

  a_r6_unique_tag: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lk_match) <= 1);
endmodule

bind tlb_sectored tlb_sectored_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_hit     (lk_hit),
  .fill_ready (fill_ready),
  .inv_valid  (inv_valid),
  .flush      (flush),
  .fill_acc   (fill_acc),
  .fill_wr    (fill_wr),
  .lk_match   (lk_match),
  .ent_v      (ent_v)
);

// File: tb/tb_tlb_sectored.sv
module tb_tlb_sectored;
  localparam int VA_W = 32, OFF_W = 12, G = 4, E = 4, PFN_W = 20, PERM_W = 3;
  localparam int TAG_W = VA_W - OFF_W - 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_hit, fill_valid = 1'b0, fill_ready;
  logic inv_valid = 1'b0, flush = 1'b0;
  logic [VA_W-1:0] lk_vaddr = '0, fill_vaddr = '0, inv_vaddr = '0;
  logic [PFN_W-1:0] lk_pfn;
  logic [PERM_W-1:0] lk_perm;
  logic [G-1:0] fill_pte_v = '0;
  logic [G*PFN_W-1:0] fill_pfn = '0;
  logic [G*PERM_W-1:0] fill_perm = '0;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tlb_sectored #(.VA_W(VA_W), .OFF_W(OFF_W), .GROUP(G), .ENTRIES(E),
                 .PFN_W(PFN_W), .PERM_W(PERM_W)) dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_perm(lk_perm),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vaddr(fill_vaddr),
    .fill_pte_v(fill_pte_v), .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .inv_valid(inv_valid), .inv_vaddr(inv_vaddr), .flush(flush)
  );

  function automatic logic [VA_W-1:0] va(int tag, int slot);
    return {TAG_W'(tag), 2'(slot), 12'h345};
  endfunction
  function automatic logic [PFN_W-1:0] exp_pfn(int tag, int slot);
    return PFN_W'(tag * 16 + slot + 'h100);
  endfunction
  function automatic logic [PERM_W-1:0] exp_perm(int tag, int slot);
    return PERM_W'(tag + slot);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive a lookup at the falling edge and sample one time unit later.
  task automatic look(string req, int tag, int slot, bit exp_hit);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = va(tag, slot);
    #1;
    chk(req, 64'(lk_hit), 64'(exp_hit));
    if (exp_hit) begin
      chk(req, 64'(lk_pfn), 64'(exp_pfn(tag, slot)));
      chk(req, 64'(lk_perm), 64'(exp_perm(tag, slot)));
    end else begin
      chk(req, 64'(lk_pfn), 64'd0);
    end
    lk_valid = 1'b0;
  endtask

  task automatic set_fill(int tag, int miss_slot, logic [G-1:0] pv);
    fill_valid = 1'b1;
    fill_vaddr = va(tag, miss_slot);
    fill_pte_v = pv;
    for (int s = 0; s < G; s++) begin
      fill_pfn[s*PFN_W +: PFN_W]    = exp_pfn(tag, s);
      fill_perm[s*PERM_W +: PERM_W] = exp_perm(tag, s);
    end
  endtask

  task automatic fill(int tag, int miss_slot, logic [G-1:0] pv);
    @(negedge clk);
    set_fill(tag, miss_slot, pv);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic look_all(string req, int tag, logic [G-1:0] hitmask);
    for (int s = 0; s < G; s++) look(req, tag, s, hitmask[s]);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset
    look_all("R1", 1, 4'b0000);
    // R5: request low never hits even for a resident slot
    fill(1, 0, 4'b1011);
    @(negedge clk); lk_valid = 1'b0; lk_vaddr = va(1, 0); #1;
    chk("R5", 64'(lk_hit), 64'd0);
    // R2/R3: whole sector kept, invalid sibling (slot 2) misses
    look_all("R2", 1, 4'b1011);
    // R4: all-invalid sector is dropped, prior entry intact
    fill(2, 1, 4'b0000);
    look_all("R4", 2, 4'b0000);
    look_all("R4", 1, 4'b1011);
    // R4: missing slot invalid though a sibling is valid
    fill(3, 0, 4'b0100);
    look_all("R4", 3, 4'b0000);
    // R6: refill of resident tag reuses its entry
    fill(1, 2, 4'b1111);
    look_all("R6", 1, 4'b1111);
    fill(4, 0, 4'b1111);
    fill(5, 1, 4'b1111);
    fill(6, 3, 4'b1111);
    for (int t = 1; t <= 6; t++) if (t != 2 && t != 3) look_all("R6", t, 4'b1111);
    // R7: full, round robin evicts entry 0 (tag 1), then entry 1 (tag 4)
    fill(7, 0, 4'b1111);
    look_all("R7", 1, 4'b0000);
    look_all("R7", 7, 4'b1111);
    fill(8, 2, 4'b1111);
    look_all("R7", 4, 4'b0000);
    for (int t = 5; t <= 8; t++) look_all("R7", t, 4'b1111);
    // R11: lookup in fill cycle sees old contents (tag 9 evicts tag 5)
    @(negedge clk);
    set_fill(9, 0, 4'b1111);
    lk_valid = 1'b1; lk_vaddr = va(9, 0); #1;
    chk("R11", 64'(lk_hit), 64'd0);
    @(negedge clk);
    fill_valid = 1'b0; #1;
    chk("R11", 64'(lk_hit), 64'd1);
    chk("R11", 64'(lk_pfn), 64'(exp_pfn(9, 0)));
    lk_valid = 1'b0;
    look_all("R7", 5, 4'b0000);
    // R9/R10: invalidate tag 8 while a fill for tag 11 is offered
    @(negedge clk);
    inv_valid = 1'b1; inv_vaddr = va(8, 3);
    set_fill(11, 0, 4'b1111); #1;
    chk("R10", 64'(fill_ready), 64'd0);
    @(negedge clk);
    inv_valid = 1'b0; fill_valid = 1'b0;
    look_all("R10", 11, 4'b0000);
    look_all("R9", 8, 4'b0000);
    look_all("R9", 7, 4'b1111);
    look_all("R9", 9, 4'b1111);
    look_all("R9", 6, 4'b1111);
    // R7: freed entry is taken before any eviction
    fill(10, 1, 4'b1111);
    for (int t = 6; t <= 10; t++) if (t != 8) look_all("R7", t, 4'b1111);
    // R8: flush clears everything
    @(negedge clk); flush = 1'b1; #1;
    chk("R10", 64'(fill_ready), 64'd0);
    @(negedge clk); flush = 1'b0;
    for (int t = 6; t <= 10; t++) look_all("R8", t, 4'b0000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule